// File: doc/BRIEF.md
# Bus Master Latency Timer

A bus master that has started a burst on a shared PCI-style bus must not hold the bus for ever. This block bounds that tenure. Software programs an 8-bit configuration register. Its upper five bits give a budget in units of eight bus clocks. When the master begins a transaction, the budget is loaded into a down-counter. The counter then decrements on every clock during which the frame signal is held.

When the counter reaches zero, the block raises an expiry flag. Expiry alone does not end the burst. The block asks the master to release frame only if the arbiter has taken the grant away. While the grant stays, the master may continue. If the grant is withdrawn after expiry, the release request follows on the next clock. The request stays up until frame is released or a new transaction starts.

Top module: `bus_tenure_timer`

## Requirements
- R1: After reset, the configuration readback is 8'h00, and both `tenure_expired` and `release_req` are 0.
- R2: A write with `cfg_wr_en` high stores `cfg_wr_data[7:3]` into the latency field. From the next clock, `cfg_rd_data[7:3]` returns that field and `cfg_rd_data[2:0]` always reads 3'b000.
- R3: A clock edge with `cycle_start` high loads the counter with the latency field times 8, which is the readback value. With the field N nonzero and frame held, `tenure_expired` rises exactly 8*N clock edges after the loading edge.
- R4: A latency field of zero makes `tenure_expired` high right after the loading edge.
- R5: Once expired, the counter stays at zero and `tenure_expired` stays high while frame is held, until `cycle_start` reloads it.
- R6: While `bus_gnt` stays high, expiry never raises `release_req`.
- R7: If `bus_gnt` is low at a clock edge where the timer is expired and frame is held, `release_req` is high after that edge.
- R8: If `bus_gnt` falls while the timer is already expired, `release_req` asserts on the next clock edge. It stays high even if the grant returns, as long as frame is held.
- R9: A clock edge with `frame_active` low ends the tenure. After that edge `release_req` and `tenure_expired` are both 0.
- R10: A configuration write during a burst does not alter the count in progress. It applies only at the next `cycle_start`.
- R11: A `cycle_start` during a burst reloads the counter and clears `release_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_data | output | 8 | Configuration readback, reserved bits zero |
| bus_gnt | input | 1 | Grant from the arbiter, high while held |
| cycle_start | input | 1 | Master begins a transaction this clock |
| frame_active | input | 1 | Frame is currently asserted by the master |
| tenure_expired | output | 1 | Tenure budget used up |
| release_req | output | 1 | Master must release frame |

## Verification
A wrong count shows as `tenure_expired` rising early or late against the exact 8*N edge count. A stale or wrongly cleared active state shows as the flag staying high or dropping one clock after frame falls. Errors in the release latch appear at `release_req` on the first clock after the grant and the expiry state disagree. Comparing every output on every cycle catches a deviation on the clock it first shows. Writes made mid-burst, and reserved-bit patterns, would otherwise hide behind a correct readback.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
    parameter int CFG_W     = 8;
    parameter int FIELD_LSB = 3;
    localparam int CNT_W    = CFG_W;
    localparam int FIELD_W  = CFG_W - FIELD_LSB;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } cfg_state_t;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    typedef struct packed {
        logic rel;
    } rel_state_t;
endpackage

// File: rtl/tenure_cfg_reg.sv
module tenure_cfg_reg
    import tenure_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_value
);
    logic [CFG_W-1:0] wmask;
    cfg_state_t       st_d, st_q;

    // writable bits: the latency field; reserved bits tied low
    for (genvar b = 0; b < CFG_W; b++) begin : g_mask
        if (b >= FIELD_LSB) begin : g_rw
            assign wmask[b] = 1'b1;
        end else begin : g_rsv
            assign wmask[b] = 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg = wr_data & wmask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_value = st_q.cfg;

    always_comb begin
        if (rst_n) begin
            assert_rsv_zero_R2: assert (st_q.cfg[FIELD_LSB-1:0] == '0);
        end
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_value[CFG_W-1:FIELD_LSB] == $past(wr_data[CFG_W-1:FIELD_LSB]));
endmodule

// File: rtl/tenure_counter.sv
module tenure_counter
    import tenure_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_start,
    input  logic             frame_active,
    input  logic [CFG_W-1:0] load_value,
    output logic             expired
);
    cnt_state_t st_d, st_q;
    logic       at_zero;

    assign at_zero = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (cycle_start) begin
            st_d.active = 1'b1;
            st_d.cnt    = load_value;
        end else if (st_q.active && !frame_active) begin
            st_d.active = 1'b0;
        end else if (st_q.active && !at_zero) begin
            st_d.cnt = st_q.cnt - {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = st_q.active && at_zero;

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> (st_q.cnt == $past(load_value)) && st_q.active);

    assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && frame_active && !cycle_start && !at_zero)
        |=> st_q.cnt == $past(st_q.cnt) - 1'b1);

    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && frame_active && !cycle_start) |=> expired);

    assert_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_active && !cycle_start) |=> !expired);
endmodule

// File: rtl/tenure_release.sv
module tenure_release
    import tenure_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expired,
    input  logic bus_gnt,
    input  logic cycle_start,
    input  logic frame_active,
    output logic release_req
);
    rel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!frame_active || cycle_start) begin
            st_d.rel = 1'b0;
        end else if (expired && !bus_gnt) begin
            st_d.rel = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign release_req = st_q.rel;

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !bus_gnt && frame_active && !cycle_start) |=> release_req);

    assert_keep_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && !release_req) |=> !release_req);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && frame_active && !cycle_start) |=> release_req);

    assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_active || cycle_start) |=> !release_req);
endmodule

// File: rtl/bus_tenure_timer.sv
module bus_tenure_timer
    import tenure_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    output logic [CFG_W-1:0] cfg_rd_data,
    input  logic             bus_gnt,
    input  logic             cycle_start,
    input  logic             frame_active,
    output logic             tenure_expired,
    output logic             release_req
);
    logic [CFG_W-1:0] cfg_value;
    logic             expired_w;

    tenure_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .cfg_value (cfg_value)
    );

    tenure_counter u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .cycle_start  (cycle_start),
        .frame_active (frame_active),
        .load_value   (cfg_value),
        .expired      (expired_w)
    );

    tenure_release u_rel (
        .clk          (clk),
        .rst_n        (rst_n),
        .expired      (expired_w),
        .bus_gnt      (bus_gnt),
        .cycle_start  (cycle_start),
        .frame_active (frame_active),
        .release_req  (release_req)
    );

    assign cfg_rd_data    = cfg_value;
    assign tenure_expired = expired_w;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_rd_data == '0) && !tenure_expired && !release_req);
endmodule

// File: tb/bus_tenure_timer_bench.sv
`timescale 1ns/100ps
module bus_tenure_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = 8'h00;
    logic [7:0] cfg_rd_data;
    logic       bus_gnt = 1'b1;
    logic       cycle_start = 1'b0;
    logic       frame_active = 1'b0;
    logic       tenure_expired;
    logic       release_req;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] m_cfg;
    logic [7:0] m_cnt;
    logic       m_act;
    logic       m_rel;

    always #2.5 clk = ~clk;

    bus_tenure_timer u_bus_tenure_timer (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .bus_gnt(bus_gnt), .cycle_start(cycle_start),
        .frame_active(frame_active), .tenure_expired(tenure_expired), .release_req(release_req)
    );

    function automatic logic m_expired();
        return m_act && (m_cnt == 8'h00);
    endfunction

    task automatic model_edge();
        logic exp_old;
        logic [7:0] cfg_old;
        exp_old = m_expired();
        cfg_old = m_cfg;
        if (!rst_n) begin
            m_cfg = 8'h00; m_cnt = 8'h00; m_act = 1'b0; m_rel = 1'b0;
        end else begin
            if (cfg_wr_en) m_cfg = {cfg_wr_data[7:3], 3'b000};
            m_rel = frame_active && !cycle_start && (m_rel || (exp_old && !bus_gnt));
            if (cycle_start) begin
                m_cnt = cfg_old; m_act = 1'b1;
            end else if (m_act && !frame_active) begin
                m_act = 1'b0;
            end else if (m_act && m_cnt != 8'h00) begin
                m_cnt = m_cnt - 8'd1;
            end
        end
    endtask

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic check_all();
        check("rd_data", cfg_rd_data, m_cfg);
        check("expired", {7'd0, tenure_expired}, {7'd0, m_expired()});
        check("release", {7'd0, release_req}, {7'd0, m_rel});
    endtask

    // one clock: inputs already driven; model follows the edge; compare at negedge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_inputs();
        cfg_wr_en = 1'b0; cycle_start = 1'b0;
    endtask

    task automatic write_cfg(logic [7:0] v);
        cfg_wr_en = 1'b1; cfg_wr_data = v; tick(); cfg_wr_en = 1'b0;
    endtask

    task automatic start_burst();
        cycle_start = 1'b1; frame_active = 1'b1; tick(); cycle_start = 1'b0;
    endtask

    task automatic end_burst();
        frame_active = 1'b0; tick();
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h5EED_0042);
        m_cfg = 8'h00; m_cnt = 8'h00; m_act = 1'b0; m_rel = 1'b0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        cur_req = "R1";
        check("reset rd", cfg_rd_data, 8'h00);
        check("reset exp", {7'd0, tenure_expired}, 8'h00);
        check("reset rel", {7'd0, release_req}, 8'h00);

        // R2: reserved bits read zero
        cur_req = "R2";
        write_cfg(8'hFF);
        check("rsv masked", cfg_rd_data, 8'hF8);
        write_cfg(8'h0F);
        check("field only", cfg_rd_data, 8'h08);

        // R3: N=1 -> expiry exactly 8 edges after load
        cur_req = "R3";
        bus_gnt = 1'b1;
        start_burst();
        for (int i = 1; i < 8; i++) begin
            tick();
            check("not yet", {7'd0, tenure_expired}, 8'h00);
        end
        tick();
        check("at 8", {7'd0, tenure_expired}, 8'h01);

        // R5 and R6: stays expired, grant held -> no release
        cur_req = "R5";
        repeat (5) tick();
        check("saturated", {7'd0, tenure_expired}, 8'h01);
        cur_req = "R6";
        check("gnt held", {7'd0, release_req}, 8'h00);

        // R8: grant removed after expiry -> release next clock, sticky
        cur_req = "R8";
        bus_gnt = 1'b0; tick();
        check("rel next", {7'd0, release_req}, 8'h01);
        bus_gnt = 1'b1; tick();
        check("rel sticky", {7'd0, release_req}, 8'h01);

        // R9: frame drop clears
        cur_req = "R9";
        end_burst();
        check("rel clr", {7'd0, release_req}, 8'h00);
        check("exp clr", {7'd0, tenure_expired}, 8'h00);

        // R4: zero field immediate expiry; R7 grant already low
        cur_req = "R4";
        write_cfg(8'h07);
        bus_gnt = 1'b0;
        start_burst();
        check("zero imm", {7'd0, tenure_expired}, 8'h01);
        cur_req = "R7";
        tick();
        check("rel gnt low", {7'd0, release_req}, 8'h01);

        // R11: restart mid-burst reloads and clears release
        cur_req = "R11";
        write_cfg(8'h10);
        start_burst();
        check("rel cleared", {7'd0, release_req}, 8'h00);
        check("reloaded", {7'd0, tenure_expired}, 8'h00);
        end_burst();

        // R10: write mid-burst does not alter count
        cur_req = "R10";
        bus_gnt = 1'b1;
        write_cfg(8'h08);
        start_burst();
        write_cfg(8'hF8);
        for (int i = 2; i < 8; i++) tick();
        check("old count 7", {7'd0, tenure_expired}, 8'h00);
        tick();
        check("old count 8", {7'd0, tenure_expired}, 8'h01);
        end_burst();

        // random phase
        cur_req = "R3";
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom;
            cfg_wr_en    = (r[3:0] == 4'd0);
            cfg_wr_data  = 8'($urandom) & 8'h1F;
            cycle_start  = (r[9:5] == 5'd0);
            frame_active = cycle_start ? 1'b1 : (r[15:10] != 6'd0);
            bus_gnt      = (r[19:16] > 4'd3);
            if (r[23:20] == 4'd0) cur_req = "R5";
            else if (r[23:20] == 4'd1) cur_req = "R8";
            else cur_req = "R3";
            tick();
        end
        idle_inputs();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule